// File: doc/BRIEF.md
# Timestamp Packer with Zone Adjustment

This block reads one timestamp as a stream of ASCII bytes in compact ISO form: a date `YYYYMMDD`, a `T`, a local time `hhmmss`, then a signed zone offset `±hhmm`. It converts the value to UTC and presents it as one packed word. The word is laid out so that a plain unsigned compare of two words orders the two instants in time. A filtering datapath can then test timestamp predicates with ordinary magnitude comparators.

Bytes are accepted one per clock while `inValid` is high. `inStart` marks the first byte of a timestamp. After the twentieth byte, a small sequencer applies the zone offset in five steps: minutes, hours, days, months, years. Each step passes a single carry or borrow to the next. The sequencer then reports either `done` or `fmtError`.

Top module: `tspk_top`

## Requirements
- R1: When `done` is high, `packedTime` holds, from bit 31 down, year minus `BASE_YEAR` (6 bits, 31:26), month (25:22), day (21:17), hour (16:12), minute (11:6) and second (5:0).
- R2: The result is local time minus the offset: a `+` offset is subtracted and a `-` offset is added, for both the offset hours and the offset minutes.
- R3: A correction that crosses a minute or hour boundary carries or borrows into the hour, and from the hour into the day.
- R4: A day carry or borrow uses the length of the month concerned: 30 or 31 days, and February with 29 days when the year is divisible by 4, otherwise 28.
- R5: A month that runs past December moves to January of the next year. A month that runs below January moves to December of the previous year.
- R6: `done` is a one-cycle pulse on the fifth rising edge after the edge that accepts the twentieth byte.
- R7: A byte other than `0`–`9` where a digit is expected, a byte other than `T` at position 8 (counting from 0), or a byte other than `+` or `-` at position 15 produces a one-cycle `fmtError` on the edge that accepts it. No `done` follows.
- R8: An offset hour above 23 or an offset minute above 59 produces a one-cycle `fmtError` on the first edge after the edge that accepts the last byte. No `done` follows.
- R9: A UTC year below `BASE_YEAR` or above `BASE_YEAR`+63 produces `fmtError` in the cycle where `done` would have appeared, and `done` stays low.
- R10: A byte with `inValid` low is not taken. A byte taken while idle without `inStart` is ignored. `inStart` during capture restarts at position 0.
- R11: While reset is held, `done` and `fmtError` are low.
- R12: The seconds field passes through the zone correction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inByte | input | 8 | ASCII character |
| inValid | input | 1 | `inByte` is present this cycle |
| inStart | input | 1 | This byte is position 0 of a timestamp |
| packedTime | output | 32 | Packed UTC value, meaningful while `done` is high |
| done | output | 1 | One-cycle pulse when the conversion completes |
| fmtError | output | 1 | One-cycle pulse on a rejected timestamp |

## Verification
The bench targets conversions where the carry or borrow has to travel the whole chain:
- New Year's Eve forward and backward. A design that dropped the year step would leave a December date stamped with the old year.
- The end of February in both a leap year and a common year. A wrong month-length lookup would yield February 30 or skip February 29.
- Month ends of 30 and 31 days. The same wrong lookup would land on a day that does not exist.
- The two extremes of the year window. These must give an error rather than a year that has silently wrapped.

Malformed bytes at each kind of position, out-of-range offsets, pauses in `inValid`, stray idle bytes and a restart in the middle of a timestamp are also driven. A sequencer off by one cycle, or one that let a rejected stamp still pulse `done`, shows up against the cycle-exact expectation that the bench compares on every clock.

// File: rtl/tspk_pkg.sv
package tspk_pkg;

  localparam int NUM_CHARS = 20;
  localparam int IDX_W     = $clog2(NUM_CHARS);

  // positions the sequencer depends on
  localparam logic [IDX_W-1:0] SEP_POS  = IDX_W'(8);
  localparam logic [IDX_W-1:0] SIGN_POS = IDX_W'(15);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(NUM_CHARS - 1);

  localparam logic [7:0] CH_ZERO  = 8'h30;
  localparam logic [7:0] CH_NINE  = 8'h39;
  localparam logic [7:0] CH_SEP   = 8'h54;
  localparam logic [7:0] CH_PLUS  = 8'h2B;
  localparam logic [7:0] CH_MINUS = 8'h2D;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CAPT, ST_MIN, ST_HR, ST_DAY, ST_MON, ST_YR
  } tspkState_t;

  typedef struct packed {
    logic             load;
    logic [IDX_W-1:0] idx;
    logic             stepMin;
    logic             stepHr;
    logic             stepDay;
    logic             stepMon;
    logic             stepYr;
  } tspkCtrl_t;

endpackage

// File: rtl/tspk_monthlen.sv
module tspk_monthlen (
  input  logic [6:0] month,
  input  logic       leap,
  output logic [4:0] days
);
  always_comb begin
    case (month)
      7'd2:                     days = leap ? 5'd29 : 5'd28;
      7'd4, 7'd6, 7'd9, 7'd11:  days = 5'd30;
      default:                  days = 5'd31;
    endcase
  end
endmodule

// File: rtl/tspk_datapath.sv
module tspk_datapath
  import tspk_pkg::*;
#(
  parameter int BASE_YEAR = 2000,
  parameter int YEAR_BITS = 6,
  localparam int OUT_W    = YEAR_BITS + 26
) (
  input  logic             clk,
  input  logic             rstN,
  input  tspkCtrl_t        ctrl,
  input  logic [7:0]       inByte,
  output logic [OUT_W-1:0] packedTime,
  output logic             offBad,
  output logic             yrInRange
);
  localparam logic [13:0] YR_LO = 14'(BASE_YEAR);
  localparam logic [13:0] YR_HI = 14'(BASE_YEAR + (1 << YEAR_BITS) - 1);

  logic [13:0] yrR;
  logic [6:0]  monR, dayR, hrR, minR, offHrR, offMinR;
  logic [5:0]  secR;
  logic        subR, carryR;

  logic [3:0]  digit;
  logic [6:0]  d7;
  assign digit = inByte[3:0];
  assign d7    = {3'd0, digit};

  // month lengths for the current and the preceding month
  logic       leap;
  logic [6:0] prevMon;
  logic [4:0] curDays, prevDays;
  assign leap    = (yrR[1:0] == 2'b00);
  assign prevMon = (monR == 7'd1) ? 7'd12 : monR - 7'd1;

  tspk_monthlen u_curLen  (.month(monR),    .leap(leap), .days(curDays));
  tspk_monthlen u_prevLen (.month(prevMon), .leap(leap), .days(prevDays));

  // per-step next values and ripple bits
  logic [6:0]  minNext, hrNext, dayNext, monNext, minTmp, hrTmp;
  logic        minCy, hrCy, dayCy, monCy;
  logic [13:0] yrNext;

  always_comb begin
    if (subR) begin
      minTmp  = offMinR;
      minCy   = (minR < offMinR);
      minNext = minCy ? (minR + 7'd60 - offMinR) : (minR - offMinR);
      hrTmp   = offHrR + {6'd0, carryR};
      hrCy    = (hrR < hrTmp);
      hrNext  = hrCy ? (hrR + 7'd24 - hrTmp) : (hrR - hrTmp);
    end else begin
      minTmp  = minR + offMinR;
      minCy   = (minTmp >= 7'd60);
      minNext = minCy ? (minTmp - 7'd60) : minTmp;
      hrTmp   = hrR + offHrR + {6'd0, carryR};
      hrCy    = (hrTmp >= 7'd24);
      hrNext  = hrCy ? (hrTmp - 7'd24) : hrTmp;
    end

    dayNext = dayR;
    dayCy   = 1'b0;
    monNext = monR;
    monCy   = 1'b0;
    yrNext  = yrR;
    if (carryR) begin
      if (subR) begin
        dayCy   = (dayR == 7'd1);
        dayNext = dayCy ? {2'd0, prevDays} : dayR - 7'd1;
        monCy   = (monR == 7'd1);
        monNext = monCy ? 7'd12 : monR - 7'd1;
        yrNext  = yrR - 14'd1;
      end else begin
        dayCy   = (dayR >= {2'd0, curDays});
        dayNext = dayCy ? 7'd1 : dayR + 7'd1;
        monCy   = (monR == 7'd12);
        monNext = monCy ? 7'd1 : monR + 7'd1;
        yrNext  = yrR + 14'd1;
      end
    end
  end

  assign yrInRange = (yrNext >= YR_LO) && (yrNext <= YR_HI);
  assign offBad    = (offHrR > 7'd23) || (offMinR > 7'd59);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      yrR     <= YR_LO;
      monR    <= 7'd1;
      dayR    <= 7'd1;
      hrR     <= '0;
      minR    <= '0;
      secR    <= '0;
      offHrR  <= '0;
      offMinR <= '0;
      subR    <= 1'b0;
      carryR  <= 1'b0;
    end else if (ctrl.load) begin
      case (ctrl.idx)
        5'd0:             yrR     <= {10'd0, digit};
        5'd1, 5'd2, 5'd3: yrR     <= yrR * 14'd10 + {10'd0, digit};
        5'd4:             monR    <= d7;
        5'd5:             monR    <= monR * 7'd10 + d7;
        5'd6:             dayR    <= d7;
        5'd7:             dayR    <= dayR * 7'd10 + d7;
        5'd9:             hrR     <= d7;
        5'd10:            hrR     <= hrR * 7'd10 + d7;
        5'd11:            minR    <= d7;
        5'd12:            minR    <= minR * 7'd10 + d7;
        5'd13:            secR    <= {2'd0, digit};
        5'd14:            secR    <= secR * 6'd10 + {2'd0, digit};
        5'd15:            subR    <= (inByte == CH_PLUS);
        5'd16:            offHrR  <= d7;
        5'd17:            offHrR  <= offHrR * 7'd10 + d7;
        5'd18:            offMinR <= d7;
        5'd19:            offMinR <= offMinR * 7'd10 + d7;
        default: ;
      endcase
    end else if (ctrl.stepMin) begin
      minR   <= minNext;
      carryR <= minCy;
    end else if (ctrl.stepHr) begin
      hrR    <= hrNext;
      carryR <= hrCy;
    end else if (ctrl.stepDay) begin
      dayR   <= dayNext;
      carryR <= dayCy;
    end else if (ctrl.stepMon) begin
      monR   <= monNext;
      carryR <= monCy;
    end else if (ctrl.stepYr) begin
      yrR    <= yrNext;
      carryR <= 1'b0;
    end
  end

  assign packedTime = {YEAR_BITS'(yrR - YR_LO), monR[3:0], dayR[4:0],
                       hrR[4:0], minR[5:0], secR};

  // R3: minute and hour steps leave legal clock values
  a_r3_min_range: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.stepMin |=> (minR < 7'd60));
  a_r3_hr_range: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.stepHr |=> (hrR < 7'd24));
  // R4: day step lands on a day that exists
  a_r4_day_range: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.stepDay |=> (dayR >= 7'd1 && dayR <= 7'd31));
  // R5: month step lands inside the calendar
  a_r5_mon_range: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.stepMon |=> (monR >= 7'd1 && monR <= 7'd12));
  // R12: seconds never touched by the correction steps
  a_r12_sec_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.stepMin || ctrl.stepHr || ctrl.stepDay || ctrl.stepMon || ctrl.stepYr)
      |=> $stable(secR));
endmodule

// File: rtl/tspk_ctrl.sv
module tspk_ctrl
  import tspk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inByte,
  input  logic       inValid,
  input  logic       inStart,
  input  logic       offBad,
  input  logic       yrInRange,
  output tspkCtrl_t  ctrl,
  output logic       done,
  output logic       fmtError
);
  tspkState_t       stateR, stateNext;
  logic [IDX_W-1:0] cntR, cntNext;
  logic             doneR, errR, doneNext, errNext;
  logic             busy, take, charOk, isDigit;
  logic [IDX_W-1:0] idx;

  assign busy    = (stateR != ST_IDLE) && (stateR != ST_CAPT);
  assign take    = inValid && !busy && (inStart || stateR == ST_CAPT);
  assign idx     = inStart ? '0 : cntR;
  assign isDigit = (inByte >= CH_ZERO) && (inByte <= CH_NINE);

  always_comb begin
    if (idx == SEP_POS)       charOk = (inByte == CH_SEP);
    else if (idx == SIGN_POS) charOk = (inByte == CH_PLUS) || (inByte == CH_MINUS);
    else                      charOk = isDigit;
  end

  always_comb begin
    stateNext = stateR;
    cntNext   = cntR;
    doneNext  = 1'b0;
    errNext   = 1'b0;
    case (stateR)
      ST_IDLE, ST_CAPT: begin
        if (take) begin
          if (!charOk) begin
            errNext   = 1'b1;
            stateNext = ST_IDLE;
          end else if (idx == LAST_POS) begin
            stateNext = ST_MIN;
          end else begin
            stateNext = ST_CAPT;
            cntNext   = idx + IDX_W'(1);
          end
        end
      end
      ST_MIN: begin
        if (offBad) begin
          errNext   = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          stateNext = ST_HR;
        end
      end
      ST_HR:  stateNext = ST_DAY;
      ST_DAY: stateNext = ST_MON;
      ST_MON: stateNext = ST_YR;
      ST_YR: begin
        doneNext  = yrInRange;
        errNext   = !yrInRange;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateR <= ST_IDLE;
      cntR   <= '0;
      doneR  <= 1'b0;
      errR   <= 1'b0;
    end else begin
      stateR <= stateNext;
      cntR   <= cntNext;
      doneR  <= doneNext;
      errR   <= errNext;
    end
  end

  always_comb begin
    ctrl.load    = take;
    ctrl.idx     = idx;
    ctrl.stepMin = (stateR == ST_MIN) && !offBad;
    ctrl.stepHr  = (stateR == ST_HR);
    ctrl.stepDay = (stateR == ST_DAY);
    ctrl.stepMon = (stateR == ST_MON);
    ctrl.stepYr  = (stateR == ST_YR);
  end

  assign done     = doneR;
  assign fmtError = errR;

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R6: the year step always ends the conversion with exactly one outcome
  a_r6_finish: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.stepYr |=> (done ^ fmtError));
  // R6: at most one correction step per cycle
  a_r6_one_step: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.stepMin, ctrl.stepHr, ctrl.stepDay, ctrl.stepMon, ctrl.stepYr}));
  // R7: a rejection never coincides with completion
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fmtError));
  // R8: a bad offset never starts the step sequence
  a_r8_no_step: assert property (@(posedge clk) disable iff (!rstN)
    (stateR == ST_MIN && offBad) |=> !ctrl.stepHr);
endmodule

// File: rtl/tspk_top.sv
module tspk_top
  import tspk_pkg::*;
#(
  parameter int BASE_YEAR = 2000,
  parameter int YEAR_BITS = 6,
  localparam int OUT_W    = YEAR_BITS + 26
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       inByte,
  input  logic             inValid,
  input  logic             inStart,
  output logic [OUT_W-1:0] packedTime,
  output logic             done,
  output logic             fmtError
);
  tspkCtrl_t ctrl;
  logic      offBad, yrInRange;

  tspk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inValid(inValid),
    .inStart(inStart), .offBad(offBad), .yrInRange(yrInRange),
    .ctrl(ctrl), .done(done), .fmtError(fmtError)
  );

  tspk_datapath #(.BASE_YEAR(BASE_YEAR), .YEAR_BITS(YEAR_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inByte(inByte),
    .packedTime(packedTime), .offBad(offBad), .yrInRange(yrInRange)
  );
endmodule

// File: tb/test_tspk_top.sv
module test_tspk_top;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 2000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  inByte = 8'h00;
  logic        inValid = 1'b0;
  logic        inStart = 1'b0;
  logic [31:0] packedTime;
  logic        done, fmtError;

  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  bit    monOn = 1'b0;
  bit    finished = 1'b0;
  int    expDoneCyc = -1;
  int    expErrCyc = -1;
  logic [31:0] expPacked = '0;
  string curReq = "R11";

  tspk_top i_tspk_top (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inValid(inValid),
    .inStart(inStart), .packedTime(packedTime), .done(done), .fmtError(fmtError)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int daysIn(int y, int m);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic int yearLen(int y);
    return (y % 4 == 0) ? 366 : 365;
  endfunction

  function automatic int dig(string s, int i);
    return int'(s[i]) - 48;
  endfunction

  task automatic check(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h (cycle %0d)", curReq, what, act, exp, cyc);
    end
  endtask

  // compares every clock against the model's expected event cycles
  always @(negedge clk) begin
    if (monOn && !finished) begin
      check(done == (cyc == expDoneCyc), "done", longint'(done), longint'(cyc == expDoneCyc));
      check(fmtError == (cyc == expErrCyc), "fmtError", longint'(fmtError),
            longint'(cyc == expErrCyc));
      if (cyc == expDoneCyc)
        check(packedTime == expPacked, "packedTime", longint'(packedTime), longint'(expPacked));
    end
  end

  // drives a full or malformed stamp; model predicts outcome and cycle
  task automatic sendStamp(string s, bit gap);
    bit bad = 1'b0;
    for (int i = 0; i < s.len() && !bad; i++) begin
      bit ok;
      @(negedge clk);
      if (gap && i == 6) begin
        inByte = "x"; inValid = 1'b0; inStart = 1'b0;   // R10: not taken
        @(negedge clk);
      end
      inByte = s[i]; inValid = 1'b1; inStart = (i == 0);
      if (i == 8)       ok = (s[i] == "T");
      else if (i == 15) ok = (s[i] == "+" || s[i] == "-");
      else              ok = (s[i] >= "0" && s[i] <= "9");
      if (!ok) begin
        bad = 1'b1;
        expErrCyc = cyc + 1;
      end else if (i == 19) begin
        int yr  = dig(s,0)*1000 + dig(s,1)*100 + dig(s,2)*10 + dig(s,3);
        int mo  = dig(s,4)*10 + dig(s,5);
        int da  = dig(s,6)*10 + dig(s,7);
        int hr  = dig(s,9)*10 + dig(s,10);
        int mi  = dig(s,11)*10 + dig(s,12);
        int se  = dig(s,13)*10 + dig(s,14);
        int oh  = dig(s,16)*10 + dig(s,17);
        int om  = dig(s,18)*10 + dig(s,19);
        int t, dn, y, m;
        if (oh > 23 || om > 59) begin
          expErrCyc = cyc + 2;
        end else begin
          dn = 0;
          for (int yy = BASE - 1; yy < yr; yy++) dn += yearLen(yy);
          for (int mm = 1; mm < mo; mm++) dn += daysIn(yr, mm);
          dn += da - 1;
          t = dn * 1440 + hr * 60 + mi;
          t = (s[15] == "+") ? t - (oh * 60 + om) : t + (oh * 60 + om);
          dn = t / 1440;
          t  = t % 1440;
          y = BASE - 1;
          while (dn >= yearLen(y)) begin dn -= yearLen(y); y++; end
          m = 1;
          while (dn >= daysIn(y, m)) begin dn -= daysIn(y, m); m++; end
          if (y < BASE || y > BASE + 63) begin
            expErrCyc = cyc + 6;
          end else begin
            expDoneCyc = cyc + 6;
            expPacked  = {6'(y - BASE), 4'(m), 5'(dn + 1), 5'(t / 60), 6'(t % 60), 6'(se)};
          end
        end
      end
    end
    @(negedge clk);
    inValid = 1'b0; inStart = 1'b0; inByte = 8'h00;
    repeat (8) @(negedge clk);
  endtask

  task automatic sendLoose(string s, bit withStart);
    for (int i = 0; i < s.len(); i++) begin
      @(negedge clk);
      inByte = s[i]; inValid = 1'b1; inStart = withStart && (i == 0);
    end
    @(negedge clk);
    inValid = 1'b0; inStart = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R11";
    check(done == 1'b0, "reset done", longint'(done), 0);
    check(fmtError == 1'b0, "reset fmtError", longint'(fmtError), 0);
    rstN = 1'b1;
    monOn = 1'b1;
    repeat (2) @(negedge clk);

    curReq = "R1";  sendStamp("20240315T101530+0000", 1'b0);
    curReq = "R2";  sendStamp("20240315T101559+0230", 1'b0);
    curReq = "R2";  sendStamp("20240315T101530-0145", 1'b0);
    curReq = "R12"; sendStamp("20240315T230047-0100", 1'b0);
    curReq = "R3";  sendStamp("20240315T003000+0100", 1'b0);
    curReq = "R3";  sendStamp("20240315T233000-0100", 1'b0);
    curReq = "R4";  sendStamp("20240301T010000+0200", 1'b0);
    curReq = "R4";  sendStamp("20230301T010000+0200", 1'b0);
    curReq = "R4";  sendStamp("20240430T230000-0200", 1'b0);
    curReq = "R4";  sendStamp("20240229T230000-0100", 1'b0);
    curReq = "R4";  sendStamp("20240501T003000+0100", 1'b0);
    curReq = "R5";  sendStamp("20231231T233000-0100", 1'b0);
    curReq = "R5";  sendStamp("20240101T001500+0030", 1'b0);
    curReq = "R6";  sendStamp("20631231T120000+0000", 1'b0);
    curReq = "R9";  sendStamp("20000101T001000+0100", 1'b0);
    curReq = "R9";  sendStamp("20631231T233000-0100", 1'b0);
    curReq = "R9";  sendStamp("20700101T120000+0000", 1'b0);
    curReq = "R7";  sendStamp("2024A315T101530+0000", 1'b0);
    curReq = "R7";  sendStamp("20240315X101530+0000", 1'b0);
    curReq = "R7";  sendStamp("20240315T101530*0000", 1'b0);
    curReq = "R8";  sendStamp("20240315T101530+2400", 1'b0);
    curReq = "R8";  sendStamp("20240315T101530-0060", 1'b0);
    curReq = "R10"; sendStamp("20241130T235900-0002", 1'b1);
    curReq = "R10"; sendLoose("Z9", 1'b0);
    repeat (8) @(negedge clk);
    curReq = "R10"; sendLoose("2024", 1'b1);
    sendStamp("20250630T180000+1800", 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule